// File: doc/BRIEF.md
# Power-On Delay Timer with Retained State

This block is a delay timer that starts a timing period on its own when supply comes up, and raises an output once a programmed number of timebase ticks has gone by. Supply is modelled by a power-good level. A separate timebase tick sets the counting rate, so the system clock only clocks the logic. The period, the output pulse width, the minimum accepted clear width and the display direction are all inputs. When the pulse width is zero, the output stays on once the period ends. Otherwise it stays on for that many ticks and then goes back to idle.

A clear input and a gate input come in asynchronously. The clear input takes effect only after it has been held long enough. It then ends the period and blocks a new one for as long as it stays high. The gate input freezes a period that is running, and counting picks up from the same value when the gate is released. When power-good drops, the working state is copied into a snapshot register held in a retained domain, and the output goes low. When power-good returns, the state is restored from the snapshot and timing continues from where it stopped.

The present value output shows either the elapsed ticks or the ticks remaining. The running flag shows whether ticks are being counted right now.

Top module: `podt_timer`

## Requirements
- R1: After the cold reset `rst_n`, the first rising edge of `pwr_good` starts a period from zero with no other input. `run_o` is high within three clock cycles, and the elapsed count is 0.
- R2: While a period runs, each tick taken when the gate is inactive raises the elapsed count by one. `pv_o` shows the elapsed count when `count_down_i`=0, and shows `preset_i` minus the elapsed count when `count_down_i`=1.
- R3: On the tick where the elapsed count reaches `preset_i`, `out_o` goes high. With a nonzero `pulse_w_i`, it goes low on the `pulse_w_i`-th tick after that. With `pulse_w_i`=0, it stays high until a clear is accepted.
- R4: A clear held for at least `clr_min_i` synchronised cycles is accepted (a value of 0 acts as 1). Acceptance drives `out_o` low and sets the elapsed count to 0. While the clear stays high, `run_o` is low and ticks are ignored. After release, a new period starts from zero.
- R5: A clear pulse shorter than `clr_min_i` synchronised cycles changes neither `pv_o` nor `out_o`.
- R6: While the gate is high, `run_o` is low and ticks leave the elapsed count unchanged. After the gate is released, counting resumes from the frozen value.
- R7: One clock after `pwr_good` goes low, `out_o` and `run_o` are low and ticks have no effect. When `pwr_good` returns, the output level and the elapsed count from before the power loss are restored, and counting resumes from that value.
- R8: After a pulse of nonzero width ends, `out_o` stays low and the elapsed count stays at `preset_i`, whatever ticks arrive, until a clear is accepted.
- R9: An accepted clear during an active output pulse ends the pulse at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low cold reset, which also clears the snapshot |
| pwr_good | input | 1 | Supply present; low means powered down |
| tick | input | 1 | Timebase tick, one clock wide |
| preset_i | input | CNT_W | Period length in ticks |
| count_down_i | input | 1 | 1 shows remaining ticks, 0 shows elapsed ticks |
| pulse_w_i | input | PW_W | Output pulse width in ticks; 0 latches the output |
| clr_min_i | input | CLRW_W | Minimum accepted clear width, in clock cycles |
| clr_in | input | 1 | Asynchronous clear request, active high |
| gate_in | input | 1 | Asynchronous pause request, active high |
| out_o | output | 1 | Timer output |
| pv_o | output | CNT_W | Present value, elapsed or remaining |
| run_o | output | 1 | High while ticks are being counted |

## Verification
A wrong elapsed count appears on `pv_o` on the cycle after the offending tick, with either display direction. A phase error appears as `out_o` being high when it should be low, or low when it should be high, or as `run_o` being high during a gate or clear. A snapshot that was captured badly only shows up after the next rise of `pwr_good`, on the first cycle after the restore, as a wrong value or a wrong output level. That is why the bench checks again right after each power cycle and once more after further ticks.

// File: rtl/podt_pkg.sv
package podt_pkg;

  typedef enum logic [2:0] {
    PH_OFF   = 3'd0,
    PH_TIME  = 3'd1,
    PH_PULSE = 3'd2,
    PH_LATCH = 3'd3,
    PH_DONE  = 3'd4,
    PH_INHIB = 3'd5
  } phase_t;

  // Elapsed value after this tick would reach the preset.
  function automatic logic period_done(input logic [31:0] elap, input logic [31:0] preset);
    return ({1'b0, elap} + 33'd1) >= {1'b0, preset};
  endfunction

  // Pulse counter after this tick would reach the width.
  function automatic logic pulse_done(input logic [31:0] pwc, input logic [31:0] width);
    return ({1'b0, pwc} + 33'd1) >= {1'b0, width};
  endfunction

  // Present value seen by the display.
  function automatic logic [31:0] pv_calc(input logic [31:0] elap, input logic [31:0] preset,
                                          input logic down);
    if (!down) return elap;
    return (preset >= elap) ? (preset - elap) : 32'd0;
  endfunction

  // Effective minimum clear width; zero acts as one.
  function automatic logic [31:0] clr_limit(input logic [31:0] min_w);
    return (min_w == 32'd0) ? 32'd1 : min_w;
  endfunction

endpackage

// File: rtl/podt_sync.sv
module podt_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/podt_clr_qual.sv
module podt_clr_qual #(
  parameter int CLRW_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_s,
  input  logic [CLRW_W-1:0] min_w,
  output logic              accept,
  output logic              held
);
  import podt_pkg::*;

  localparam logic [CLRW_W-1:0] CNT_MAX = '1;

  logic [CLRW_W-1:0] cnt;
  logic              reach;

  assign reach  = period_done(32'(cnt), clr_limit(32'(min_w)));
  assign accept = clr_s && !held && reach;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      held <= 1'b0;
    end else begin
      if (!clr_s)              cnt <= '0;
      else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      held <= clr_s && (held || reach);
    end
  end
endmodule

// File: rtl/podt_retain.sv
module podt_retain #(
  parameter int              W         = 8,
  parameter logic [W-1:0]    RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)  q <= RESET_VAL;
    else if (ld) q <= d;
endmodule

// File: rtl/podt_timer.sv
module podt_timer #(
  parameter int CNT_W  = 20,
  parameter int PW_W   = 16,
  parameter int CLRW_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              tick,
  input  logic [CNT_W-1:0]  preset_i,
  input  logic              count_down_i,
  input  logic [PW_W-1:0]   pulse_w_i,
  input  logic [CLRW_W-1:0] clr_min_i,
  input  logic              clr_in,
  input  logic              gate_in,
  output logic              out_o,
  output logic [CNT_W-1:0]  pv_o,
  output logic              run_o
);
  import podt_pkg::*;

  localparam int SNAP_W = 3 + CNT_W + PW_W;
  localparam logic [SNAP_W-1:0] SNAP_INIT = {PH_TIME, {CNT_W{1'b0}}, {PW_W{1'b0}}};

  // synchronised asynchronous controls
  logic clr_s, gate_s;
  podt_sync #(.W(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({clr_in, gate_in}), .q({clr_s, gate_s})
  );

  logic clr_accept, clr_held;
  podt_clr_qual #(.CLRW_W(CLRW_W)) u_qual (
    .clk(clk), .rst_n(rst_n), .clr_s(clr_s), .min_w(clr_min_i),
    .accept(clr_accept), .held(clr_held)
  );

  // working state
  phase_t            phase, phase_n;
  logic [CNT_W-1:0]  elap, elap_n;
  logic [PW_W-1:0]   pwc, pwc_n;
  logic              pwr_q;

  // named events
  logic pwr_fall, pwr_rise, tick_run, period_end, pulse_step, pulse_end;

  assign pwr_fall   = pwr_q && !pwr_good;
  assign pwr_rise   = !pwr_q && pwr_good;
  assign tick_run   = pwr_good && pwr_q && !clr_accept && (phase == PH_TIME) && tick && !gate_s;
  assign period_end = tick_run && period_done(32'(elap), 32'(preset_i));
  assign pulse_step = pwr_good && pwr_q && !clr_accept && (phase == PH_PULSE) && tick;
  assign pulse_end  = pulse_step && pulse_done(32'(pwc), 32'(pulse_w_i));

  // retention snapshot
  logic [SNAP_W-1:0] snap_q;
  podt_retain #(.W(SNAP_W), .RESET_VAL(SNAP_INIT)) u_snap (
    .clk(clk), .rst_n(rst_n), .ld(pwr_fall), .d({phase, elap, pwc}), .q(snap_q)
  );

  always_comb begin
    phase_n = phase;
    elap_n  = elap;
    pwc_n   = pwc;
    if (!pwr_good) begin
      phase_n = PH_OFF;
      elap_n  = '0;
      pwc_n   = '0;
    end else if (clr_accept) begin
      phase_n = PH_INHIB;
      elap_n  = '0;
      pwc_n   = '0;
    end else if (pwr_rise) begin
      phase_n = phase_t'(snap_q[SNAP_W-1 -: 3]);
      elap_n  = snap_q[PW_W +: CNT_W];
      pwc_n   = snap_q[PW_W-1:0];
    end else begin
      case (phase)
        PH_TIME: begin
          if (period_end) begin
            elap_n  = preset_i;
            pwc_n   = '0;
            phase_n = (pulse_w_i == '0) ? PH_LATCH : PH_PULSE;
          end else if (tick_run) begin
            elap_n = elap + 1'b1;
          end
        end
        PH_PULSE: begin
          if (pulse_end)       phase_n = PH_DONE;
          else if (pulse_step) pwc_n   = pwc + 1'b1;
        end
        PH_INHIB: if (!clr_held) phase_n = PH_TIME;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_OFF;
      elap  <= '0;
      pwc   <= '0;
      pwr_q <= 1'b0;
    end else begin
      phase <= phase_n;
      elap  <= elap_n;
      pwc   <= pwc_n;
      pwr_q <= pwr_good;
    end
  end

  assign out_o = (phase == PH_PULSE) || (phase == PH_LATCH);
  assign run_o = (phase == PH_TIME) && !gate_s;
  assign pv_o  = CNT_W'(pv_calc(32'(elap), 32'(preset_i), count_down_i));

endmodule

// File: rtl/podt_timer_chk.sv
module podt_timer_chk #(
  parameter int CNT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_good,
  input logic             out_o,
  input logic             run_o,
  input logic             gate_s,
  input logic             clr_accept,
  input logic             tick_run,
  input logic             period_end,
  input logic [CNT_W-1:0] elap,
  input logic [2:0]       phase
);
  import podt_pkg::*;

  p_off_unpowered_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (!out_o && !run_o));

  p_tick_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_run && !period_end) |=> (elap == $past(elap) + 1'b1));

  p_gate_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_TIME && gate_s && pwr_good && !clr_accept) |=> $stable(elap));

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_accept && pwr_good) |=> (!out_o && !run_o && elap == '0));

  p_latch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LATCH && pwr_good && !clr_accept) |=> out_o);

  p_no_retrigger_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DONE && pwr_good && !clr_accept) |=> !out_o);
endmodule

bind podt_timer podt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .out_o(out_o), .run_o(run_o),
  .gate_s(gate_s), .clr_accept(clr_accept), .tick_run(tick_run),
  .period_end(period_end), .elap(elap), .phase(phase)
);

// File: tb/podt_timer_tb.sv
module podt_timer_tb;
  localparam int CNT_W = 20, PW_W = 16, CLRW_W = 8;

  logic clk = 1'b0, rst_n = 1'b0, pwr_good = 1'b0, tick = 1'b0;
  logic [CNT_W-1:0]  preset_i = '0;
  logic              count_down_i = 1'b0;
  logic [PW_W-1:0]   pulse_w_i = '0;
  logic [CLRW_W-1:0] clr_min_i = 8'd4;
  logic clr_in = 1'b0, gate_in = 1'b0;
  logic out_o, run_o;
  logic [CNT_W-1:0] pv_o;

  int total = 0, fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  podt_timer #(.CNT_W(CNT_W), .PW_W(PW_W), .CLRW_W(CLRW_W)) u_dut (.*);

  function automatic int exp_pv(int e, int p, bit down);
    if (down) return (p >= e) ? p - e : 0;
    return e;
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
    settle(1);
  endtask

  task automatic clr_pulse(int cyc);
    @(negedge clk) clr_in = 1'b1;
    settle(cyc);
    clr_in = 1'b0;
    settle(5);
  endtask

  task automatic power_cycle();
    @(negedge clk) pwr_good = 1'b0;
    settle(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    settle(3);
    chk("reset out", out_o, 0);
    chk("reset run", run_o, 0);
    rst_n = 1'b1;
    settle(2);

    // R1: power-up starts timing automatically
    preset_i = 20'd10; pulse_w_i = 16'd3;
    @(negedge clk) pwr_good = 1'b1;
    settle(3);
    chk("R1 run", run_o, 1);
    chk("R1 pv", pv_o, 0);

    // R2: counting up and down display
    ticks(4);
    chk("R2 up pv", pv_o, 4);
    count_down_i = 1'b1; settle(1);
    chk("R2 down pv", pv_o, 6);

    // R6: gate freezes and resumes
    gate_in = 1'b1; settle(4);
    chk("R6 run low", run_o, 0);
    ticks(3);
    chk("R6 frozen", pv_o, 6);
    gate_in = 1'b0; settle(4);
    ticks(2);
    chk("R6 resumed", pv_o, 4);

    // R5: short clear ignored
    clr_pulse(2);
    chk("R5 pv", pv_o, 4);
    chk("R5 out", out_o, 0);

    // R7: power loss and restore mid-period
    power_cycle();
    chk("R7 out off", out_o, 0);
    chk("R7 run off", run_o, 0);
    ticks(3);
    @(negedge clk) pwr_good = 1'b1;
    settle(2);
    chk("R7 restored pv", pv_o, 4);
    chk("R7 running", run_o, 1);

    // R3 / R8: pulse of width 3, then no retrigger
    ticks(3);
    chk("R3 before end", out_o, 0);
    ticks(1);
    chk("R3 pulse on", out_o, 1);
    ticks(2);
    chk("R3 pulse still on", out_o, 1);
    ticks(1);
    chk("R3 pulse off", out_o, 0);
    ticks(5);
    chk("R8 stays off", out_o, 0);
    chk("R8 pv at preset", pv_o, 0);

    // R4: accepted clear inhibits while held
    count_down_i = 1'b0;
    @(negedge clk) clr_in = 1'b1;
    settle(10);
    chk("R4 pv cleared", pv_o, 0);
    chk("R4 run low", run_o, 0);
    ticks(3);
    chk("R4 inhibited", pv_o, 0);
    clr_in = 1'b0; settle(5);
    chk("R4 restart run", run_o, 1);
    ticks(2);
    chk("R4 new period", pv_o, 2);

    // R3 latched output with pulse width 0, survives power cycle (R7)
    clr_pulse(8);
    preset_i = 20'd5; pulse_w_i = 16'd0;
    ticks(5);
    chk("R3 latch on", out_o, 1);
    ticks(10);
    chk("R3 latch holds", out_o, 1);
    power_cycle();
    chk("R7 latch off unpowered", out_o, 0);
    @(negedge clk) pwr_good = 1'b1;
    settle(2);
    chk("R7 latch restored", out_o, 1);
    clr_pulse(8);
    chk("R4 clears latch", out_o, 0);

    // R9: clear cuts an active pulse
    preset_i = 20'd3; pulse_w_i = 16'd8;
    ticks(3);
    chk("R9 pulse on", out_o, 1);
    ticks(2);
    @(negedge clk) clr_in = 1'b1;
    settle(8);
    chk("R9 pulse cut", out_o, 0);
    clr_in = 1'b0; settle(5);

    // Random trials: R2, R6, R3
    for (int t = 0; t < 8; t++) begin
      int p, w, e, n;
      bit d;
      clr_pulse(6);
      p = 5 + int'($urandom % 30);
      w = 1 + int'($urandom % 4);
      d = 1'($urandom % 2);
      preset_i = CNT_W'(p); pulse_w_i = PW_W'(w); count_down_i = d;
      n = int'($urandom % (p - 1));
      e = 0;
      for (int k = 0; k < n; k++) begin
        if ($urandom % 4 == 0) begin
          gate_in = 1'b1; settle(4);
          ticks(1);
          gate_in = 1'b0; settle(4);
        end else begin
          ticks(1);
          e++;
        end
      end
      chk("R2 R6 random pv", pv_o, exp_pv(e, p, d));
      ticks(p - e);
      chk("R3 random on", out_o, 1);
      ticks(w);
      chk("R3 random off", out_o, 0);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule